// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block sits beside a serial receiver and its receive FIFO. It raises a flag when characters have been left in the FIFO for too long with nothing new arriving. The host's interrupt logic uses the flag to collect a partial batch that never reached the FIFO's fill threshold. The wait is measured in character times rather than clock cycles. One character time is the configured frame length, in bits, counted on a baud tick that pulses once per bit period.

A counter of bit ticks divides the baud tick down to one pulse per character. A second counter tallies whole characters up to a parameterised limit, which defaults to four, and then holds there. The flag follows that saturated state. Four events restart the measurement: a host read of the FIFO, a FIFO reset, a newly detected start bit, and the FIFO being empty. The flag is also masked at once while the FIFO is empty or FIFO operation is switched off. A reset synchroniser inside the block releases the asynchronous reset on a clock edge.

Top module: `rxto_detector`

## Requirements
- R1: After reset, `timeout_o` is 0 and the character and bit counts start from zero.
- R2: With FIFO mode on, the FIFO non-empty and no restarting event, `timeout_o` rises after exactly `CHARS * frame_bits` cycles in which `bit_tick` was 1, and not one tick earlier. The rise is visible in the cycle after the edge that samples the final tick.
- R3: A character time equals the `frame_bits` input value in bit ticks. Changing it changes the tick count needed for the timeout, for example 28 ticks at 7 bits and 40 ticks at 10 bits when `CHARS` is 4.
- R4: A 1 on `fifo_rd` clears `timeout_o` from the next cycle on and restarts the count from zero.
- R5: A 1 on `fifo_rst` clears `timeout_o` from the next cycle on and restarts the count from zero.
- R6: A 1 on `start_det` clears `timeout_o` from the next cycle on and restarts the count from zero.
- R7: While `fifo_empty` is 1, `timeout_o` is 0 in the same cycle and the count is held at zero.
- R8: While `fifo_mode` is 0, `timeout_o` is 0 and no ticks are counted.
- R9: Once reached, the timeout holds. `timeout_o` stays 1 through idle cycles and further ticks until a restarting event, an empty FIFO or FIFO mode being turned off.
- R10: When a restarting event falls in the same cycle as the tick that would complete the timeout, the event wins: `timeout_o` stays 0 and counting restarts from zero.
- R11: Cycles with `bit_tick` at 0 never advance the count, so `timeout_o` only rises in the cycle after a sampled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 enables FIFO operation and the timeout |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| frame_bits | input | FRAME_W | Bits per frame: start, data, parity and stop |
| fifo_empty | input | 1 | Receive FIFO holds no characters |
| fifo_rd | input | 1 | Host read strobe of the receive FIFO |
| fifo_rst | input | 1 | Receive FIFO reset strobe |
| start_det | input | 1 | Start bit detected on the serial input |
| timeout_o | output | 1 | Character timeout flag to the interrupt logic |

## Verification
The bench uses the defaults: `CHARS` = 4 and a 4-bit `frame_bits`. With those values a timeout takes at most 60 ticks, so saturation, holding and every restart path can be reached many times within a short run. Frame lengths from 7 to 15 bits are tried, which exercises the divider wrap at different counts. The clear-versus-final-tick collision is driven directly, because random stimulus would rarely produce it.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  // Causes that restart the timeout measurement.
  typedef struct packed {
    logic host_read;
    logic fifo_reset;
    logic new_start;
    logic held_off;
  } rxto_restart_t;

  function automatic logic rxto_any_restart(input rxto_restart_t r);
    return r.host_read | r.fifo_reset | r.new_start | r.held_off;
  endfunction
endpackage

// File: rtl/rxto_restart_gen.sv
module rxto_restart_gen
  import rxto_pkg::*;
(
  input  logic fifo_mode,
  input  logic fifo_empty,
  input  logic fifo_rd,
  input  logic fifo_rst,
  input  logic start_det,
  output logic restart
);
  rxto_restart_t cause;

  always_comb begin
    cause.host_read  = fifo_rd;
    cause.fifo_reset = fifo_rst;
    cause.new_start  = start_det;
    cause.held_off   = fifo_empty | ~fifo_mode;
    restart          = rxto_any_restart(cause);
  end
endmodule

// File: rtl/rxto_bit_div.sv
module rxto_bit_div #(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               char_pulse
);
  logic [FRAME_W-1:0] bit_q, bit_d;
  logic [FRAME_W:0]   bit_inc;
  logic               adv;
  logic               wrap;

  always_comb begin
    bit_inc    = {1'b0, bit_q} + {{FRAME_W{1'b0}}, 1'b1};
    adv        = bit_tick & run & ~restart;
    wrap       = bit_inc >= {1'b0, frame_bits};
    char_pulse = adv & wrap;
    bit_d      = bit_q;
    if (restart)
      bit_d = '0;
    else if (adv)
      bit_d = wrap ? '0 : bit_inc[FRAME_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bit_q <= '0;
    else
      bit_q <= bit_d;
  end
endmodule

// File: rtl/rxto_char_cnt.sv
module rxto_char_cnt #(
  parameter int CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic char_pulse,
  output logic saturated
);
  localparam int CNT_W = $clog2(CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHARS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    saturated = (cnt_q == LIMIT);
    cnt_d     = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (char_pulse && !saturated)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxto_detector.sv
module rxto_detector #(
  parameter int FRAME_W = 4,
  parameter int CHARS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic               fifo_empty,
  input  logic               fifo_rd,
  input  logic               fifo_rst,
  input  logic               start_det,
  output logic               timeout_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       restart;
  logic       char_pulse;
  logic       saturated;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rxto_restart_gen u_restart (
    .fifo_mode  (fifo_mode),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .fifo_rst   (fifo_rst),
    .start_det  (start_det),
    .restart    (restart)
  );

  rxto_bit_div #(.FRAME_W(FRAME_W)) u_bit_div (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart    (restart),
    .run        (~saturated),
    .bit_tick   (bit_tick),
    .frame_bits (frame_bits),
    .char_pulse (char_pulse)
  );

  rxto_char_cnt #(.CHARS(CHARS)) u_char_cnt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart    (restart),
    .char_pulse (char_pulse),
    .saturated  (saturated)
  );

  assign timeout_o = saturated & ~fifo_empty & fifo_mode;
endmodule

// File: rtl/rxto_detector_chk.sv
module rxto_detector_chk #(
  parameter int FRAME_W = 4,
  parameter int CHARS   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifo_mode,
  input logic               bit_tick,
  input logic [FRAME_W-1:0] frame_bits,
  input logic               fifo_empty,
  input logic               fifo_rd,
  input logic               fifo_rst,
  input logic               start_det,
  input logic               timeout_o
);
  p_empty_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !timeout_o);

  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !timeout_o);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !timeout_o);

  p_reset_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> !timeout_o);

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !timeout_o);

  p_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !fifo_rd && !fifo_rst && !start_det)
      |=> (timeout_o || fifo_empty || !fifo_mode));

  p_rise_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(bit_tick));
endmodule

bind rxto_detector rxto_detector_chk #(.FRAME_W(FRAME_W), .CHARS(CHARS)) u_chk (.*);

// File: tb/rxto_detector_tb.sv
module rxto_detector_tb;
  localparam int FRAME_W = 4;
  localparam int CHARS   = 4;

  logic               clk;
  logic               rst_n;
  logic               fifo_mode;
  logic               bit_tick;
  logic [FRAME_W-1:0] frame_bits;
  logic               fifo_empty;
  logic               fifo_rd;
  logic               fifo_rst;
  logic               start_det;
  logic               timeout_o;

  int n_checks = 0;
  int n_fail   = 0;
  int m_bits   = 0;
  int m_chars  = 0;
  bit finished = 0;

  rxto_detector #(.FRAME_W(FRAME_W), .CHARS(CHARS)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .bit_tick(bit_tick),
    .frame_bits(frame_bits), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .fifo_rst(fifo_rst), .start_det(start_det), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: ticks within a character, then characters.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bits = 0; m_chars = 0;
    end else if (fifo_rd || fifo_rst || start_det || fifo_empty || !fifo_mode) begin
      m_bits = 0; m_chars = 0;
    end else if (bit_tick && m_chars < CHARS) begin
      if (m_bits + 1 >= int'(frame_bits)) begin
        m_bits = 0; m_chars = m_chars + 1;
      end else begin
        m_bits = m_bits + 1;
      end
    end
  end

  function automatic logic model_flag();
    return (m_chars == CHARS) && !fifo_empty && fifo_mode;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_checks++;
      if (timeout_o !== model_flag()) begin
        n_fail++;
        $display("FAIL R2 model compare at %0t: actual %0b expected %0b", $time, timeout_o, model_flag());
      end
    end
  end

  task automatic check(input string req, input logic exp);
    @(negedge clk);
    n_checks++;
    if (timeout_o !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, timeout_o, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic rd, input logic fr, input logic st);
    @(posedge clk);
    #1;
    bit_tick = t; fifo_rd = rd; fifo_rst = fr; start_det = st;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 0; fifo_mode = 1; bit_tick = 0; frame_bits = 4'd10;
    fifo_empty = 0; fifo_rd = 0; fifo_rst = 0; start_det = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) cyc(0, 0, 0, 0);
    check("R1 reset", 1'b0);

    ticks(CHARS * 10 - 1);  check("R2 one tick short", 1'b0);
    ticks(1);               check("R2 reached", 1'b1);
    repeat (20) cyc(0, 0, 0, 0);
    check("R11 idle keeps state", 1'b1);
    ticks(15);              check("R9 saturated holds", 1'b1);

    cyc(0, 1, 0, 0); cyc(0, 0, 0, 0); check("R4 read clears", 1'b0);
    ticks(CHARS * 10 - 1);  check("R4 restart short", 1'b0);
    ticks(1);               check("R4 restart reached", 1'b1);

    cyc(0, 0, 1, 0); cyc(0, 0, 0, 0); check("R5 fifo reset clears", 1'b0);
    ticks(CHARS * 10);      check("R5 rebuilt", 1'b1);

    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); check("R6 start clears", 1'b0);
    ticks(CHARS * 10 - 1);  check("R6 restart short", 1'b0);
    // R10: start bit lands with the final tick
    cyc(1, 0, 0, 1); cyc(0, 0, 0, 0); check("R10 clear wins", 1'b0);
    ticks(CHARS * 10 - 1);  check("R10 counted from zero", 1'b0);
    ticks(1);               check("R10 later reached", 1'b1);

    @(posedge clk); #1 fifo_empty = 1;
    check("R7 empty masks at once", 1'b0);
    @(posedge clk); #1 fifo_empty = 0;
    check("R7 count was cleared", 1'b0);
    ticks(CHARS * 10 - 1);  check("R7 restart short", 1'b0);
    ticks(1);               check("R7 restart reached", 1'b1);

    @(posedge clk); #1 fifo_mode = 0;
    check("R8 mode off masks", 1'b0);
    ticks(60);              check("R8 no counting", 1'b0);
    @(posedge clk); #1 fifo_mode = 1;
    ticks(CHARS * 10 - 1);  check("R8 resumed short", 1'b0);
    ticks(1);               check("R8 resumed reached", 1'b1);

    cyc(0, 1, 0, 0); frame_bits = 4'd7; cyc(0, 0, 0, 0);
    ticks(CHARS * 7 - 1);   check("R3 seven-bit short", 1'b0);
    ticks(1);               check("R3 seven-bit reached", 1'b1);
    cyc(0, 1, 0, 0); frame_bits = 4'd15; cyc(0, 0, 0, 0);
    ticks(CHARS * 15 - 1);  check("R3 fifteen-bit short", 1'b0);
    ticks(1);               check("R3 fifteen-bit reached", 1'b1);

    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      #1;
      bit_tick  = ($urandom_range(1) == 1);
      fifo_rd   = ($urandom_range(199) == 0);
      fifo_rst  = ($urandom_range(499) == 0);
      start_det = ($urandom_range(149) == 0);
      if ($urandom_range(299) == 0) fifo_empty = ~fifo_empty;
      if ($urandom_range(999) == 0) fifo_mode = ~fifo_mode;
      if (fifo_rd) frame_bits = FRAME_W'(7 + $urandom_range(8));
    end
    @(negedge clk);
    summary();
  end
endmodule